// File: doc/BRIEF.md
# Performance monitor register access gate

This block holds a small bank of performance-monitor registers: three 64-bit mode-control registers (control 0, control 1, control 2) and six 32-bit event counters. One request port carries both privileged and user-mode accesses, told apart by a user flag. Privileged accesses read and write every register in full. User-mode accesses pass through a permission gate. That gate is steered by a 2-bit rights field in control 0, at bits 19:18. User-mode accesses also pass through bit masks, so user code sees and changes only a few fields.

User-mode register numbers are offset from the privileged ones. The block adds the offset back, so both views land on the same physical register. A denied access returns a fault code in place of data and leaves every register untouched. Each request completes in one clock. The block is always ready, and the response appears in the cycle after the request.

Default register numbers, privileged view:

| Register | Number |
|---|---|
| Control 2 | 0x311 |
| Counters 1 to 6 | 0x313 to 0x318 |
| Control 0 | 0x31B |
| Control 1 | 0x31E |

Top module: `pmu_access_gate`

## Requirements
- R1: After reset, every register reads zero, and `rsp_valid` and `rsp_fault` are low.
- R2: A privileged access is never faulted, whatever the rights field holds. Control registers are read and written as all 64 bits. A counter is written from `req_wdata[31:0]` and read zero-extended to 64 bits.
- R3: A user read of the gated group (control 0, control 2, counters) is refused with fault code 01 (facility unavailable) when the rights field, control 0 bits 19:18, is 01. A refused read returns data zero. For the field values 00, 10 and 11 the read is served with fault code 00.
- R4: A user write to the gated group succeeds only when the rights field is 10 or 11. With 01 the write faults with code 01; with 00 it faults with code 10 (hypervisor assist). A faulted write leaves the register unchanged. Fault code 11 never occurs.
- R5: When the rights field is 11, any user read or write of counter 5 or counter 6 faults with code 01 and changes nothing. Counters 1 to 4 stay accessible.
- R6: A user read of control 0 returns its value ANDed with `CTL0_UMASK` (default 0x8400_0080: freeze, alert-enable and alert-occurred bits). A user read of control 2 returns its value ANDed with `CTL2_UMASK` (default 0x0040_2010_0804_0200: the six per-counter user-freeze bits).
- R7: A permitted user write to control 0 or control 2 stores (new AND mask) OR (old AND NOT mask). Unmasked bits are kept.
- R8: User register numbers are the privileged numbers minus 0x10. User 0x303 to 0x308 reach counters 1 to 6, user 0x30B reaches control 0, and user 0x301 reaches control 2.
- R9: An access to an unmapped number returns zero with fault code 00 and changes no register. This includes a user access that would alias onto control 1 (user 0x30E).
- R10: `req_ready` is always high. A request accepted at a clock edge gives `rsp_valid` high after that edge. Write responses carry data zero. With no request, `rsp_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high |
| req_user | input | 1 | 1 = user-mode access, 0 = privileged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register number |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data (zero for writes and faults) |
| rsp_fault | output | 2 | 00 none, 01 facility unavailable, 10 hypervisor assist |

## Verification
The gate is driven with the same user reads and writes under all four rights-field values. This separates the refusal on 01 from the refusal on 00, and both from the two permitting values. The counter 5 and 6 lockout under 11 is contrasted with counter 4, which is still served under the same field value. Alternating bit patterns in the old and new values of control 2 show that the masked merge replaces exactly the masked bits. Privileged read-back after each faulted or unmapped user write shows whether the write left anything changed.

// File: rtl/pmu_access_gate.sv
module pmu_access_gate #(
  parameter int          AW         = 10,
  parameter int          DW         = 64,
  parameter int          CW         = 32,
  parameter int          PCF_LSB    = 18,
  parameter int          A_CTL0     = 'h31B,
  parameter int          A_CTL1     = 'h31E,
  parameter int          A_CTL2     = 'h311,
  parameter int          A_CNT      = 'h313,
  parameter int          UOFS       = 'h10,
  parameter logic [63:0] CTL0_UMASK = 64'h0000_0000_8400_0080,
  parameter logic [63:0] CTL2_UMASK = 64'h0040_2010_0804_0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_user,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    rsp_fault
);
  localparam int NCNT = 6;
  localparam logic [1:0] F_NONE = 2'b00, F_FU = 2'b01, F_HV = 2'b10;

  logic [DW-1:0] ctl0, ctl1, ctl2;
  logic [CW-1:0] cnt [NCNT];

  logic [AW-1:0] eff, off;
  logic [2:0]    idx;
  logic          hit_c0, hit_c1, hit_c2, hit_cnt, c56, gated;
  logic [1:0]    pcf, fault;
  logic [DW-1:0] rd_full, rd_user, rd_next, m0, m2;
  logic          wen;

  assign req_ready = 1'b1;
  assign eff     = req_user ? req_addr + AW'(UOFS) : req_addr;
  assign off     = eff - AW'(A_CNT);
  assign idx     = off[2:0];
  assign hit_c0  = eff == AW'(A_CTL0);
  assign hit_c1  = (eff == AW'(A_CTL1)) && !req_user;
  assign hit_c2  = eff == AW'(A_CTL2);
  assign hit_cnt = off < AW'(NCNT);
  assign c56     = hit_cnt && idx >= 3'd4;
  assign gated   = hit_c0 || hit_c2 || hit_cnt;
  assign pcf     = ctl0[PCF_LSB+1:PCF_LSB];

  always_comb begin
    fault = F_NONE;
    if (req_user && gated) begin
      if (c56 && pcf == 2'b11)          fault = F_FU;
      else if (!req_write && pcf == 2'b01) fault = F_FU;
      else if (req_write && !pcf[1])    fault = pcf[0] ? F_FU : F_HV;
    end
  end

  always_comb begin
    rd_full = '0;
    if (hit_c0) rd_full = ctl0;
    if (hit_c1) rd_full = ctl1;
    if (hit_c2) rd_full = ctl2;
    for (int i = 0; i < NCNT; i++)
      if (hit_cnt && idx == 3'(i)) rd_full = DW'(cnt[i]);
  end

  assign rd_user = hit_c0 ? (ctl0 & CTL0_UMASK) :
                   hit_c2 ? (ctl2 & CTL2_UMASK) : rd_full;
  assign rd_next = (req_write || fault != F_NONE) ? '0 :
                   (req_user ? rd_user : rd_full);
  assign wen     = req_valid && req_write && fault == F_NONE;
  assign m0      = req_user ? CTL0_UMASK : '1;
  assign m2      = req_user ? CTL2_UMASK : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= F_NONE;
      ctl0      <= '0;
      ctl1      <= '0;
      ctl2      <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_next : '0;
      rsp_fault <= req_valid ? fault : F_NONE;
      if (wen && hit_c0) ctl0 <= (ctl0 & ~m0) | (req_wdata & m0);
      if (wen && hit_c2) ctl2 <= (ctl2 & ~m2) | (req_wdata & m2);
      if (wen && hit_c1) ctl1 <= req_wdata;
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt[g] <= '0;
      else if (wen && hit_cnt && idx == 3'(g))    cnt[g] <= req_wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/pmu_access_gate_chk.sv
module pmu_access_gate_chk #(
  parameter int          AW         = 10,
  parameter int          DW         = 64,
  parameter int          PCF_LSB    = 18,
  parameter int          A_CTL0     = 'h31B,
  parameter int          A_CTL2     = 'h311,
  parameter int          A_CNT      = 'h313,
  parameter int          UOFS       = 'h10,
  parameter logic [63:0] CTL0_UMASK = 64'h0000_0000_8400_0080,
  parameter logic [63:0] CTL2_UMASK = 64'h0040_2010_0804_0200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_user,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic [1:0]    rsp_fault,
  input logic [DW-1:0] ctl0,
  input logic [DW-1:0] ctl2
);
  logic u_grp, u_c56;
  assign u_grp = (req_addr == AW'(A_CTL0 - UOFS)) || (req_addr == AW'(A_CTL2 - UOFS)) ||
                 (req_addr >= AW'(A_CNT - UOFS) && req_addr <= AW'(A_CNT + 5 - UOFS));
  assign u_c56 = (req_addr == AW'(A_CNT + 4 - UOFS)) || (req_addr == AW'(A_CNT + 5 - UOFS));

  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_fault_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_rdata == '0);
  p_fault_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'b11);
  p_hv_on_zero_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_write && u_grp && !u_c56 &&
     ctl0[PCF_LSB+1:PCF_LSB] == 2'b00) |=> rsp_fault == 2'b10);
  p_c56_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && u_c56 && ctl0[PCF_LSB+1:PCF_LSB] == 2'b11)
    |=> rsp_fault == 2'b01);
  p_unmasked_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_write) |=>
    ((ctl0 & ~CTL0_UMASK) == $past(ctl0 & ~CTL0_UMASK)) &&
    ((ctl2 & ~CTL2_UMASK) == $past(ctl2 & ~CTL2_UMASK)));
endmodule

bind pmu_access_gate pmu_access_gate_chk #(
  .AW(AW), .DW(DW), .PCF_LSB(PCF_LSB), .A_CTL0(A_CTL0), .A_CTL2(A_CTL2),
  .A_CNT(A_CNT), .UOFS(UOFS), .CTL0_UMASK(CTL0_UMASK), .CTL2_UMASK(CTL2_UMASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .ctl0(ctl0), .ctl2(ctl2)
);

// File: tb/pmu_access_gate_bench.sv
`timescale 1ns/1ps
module pmu_access_gate_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_user = 0, req_write = 0;
  logic [9:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic [1:0]  rsp_fault;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pmu_access_gate u_pmu_access_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_user(req_user), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault)
  );

  typedef struct packed {
    logic        u;
    logic        w;
    logic [9:0]  a;
    logic [63:0] d;
    logic [63:0] er;
    logic [1:0]  ef;
    logic [7:0]  r;
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{0,1,10'h31B,64'hFFFF_FFFF_FFF3_FFFF,64'h0,2'b00,2},  // R2
    '{0,0,10'h31B,64'h0,64'hFFFF_FFFF_FFF3_FFFF,2'b00,2},  // R2
    '{1,0,10'h30B,64'h0,64'h8400_0080,2'b00,6},            // R6, R3 field 00 read ok
    '{1,1,10'h30B,64'h0,64'h0,2'b10,4},                    // R4 hv fault
    '{0,0,10'h31B,64'h0,64'hFFFF_FFFF_FFF3_FFFF,2'b00,4},  // R4 unchanged
    '{0,1,10'h31B,64'h0004_0000,64'h0,2'b00,3},            // field = 01
    '{1,0,10'h30B,64'h0,64'h0,2'b01,3},                    // R3
    '{1,1,10'h301,ONES,64'h0,2'b01,4},                     // R4 fu fault
    '{1,0,10'h303,64'h0,64'h0,2'b01,3},                    // R3
    '{1,0,10'h30E,64'h0,64'h0,2'b00,9},                    // R9
    '{0,1,10'h31B,64'h1234_5678_0008_0000,64'h0,2'b00,4},  // field = 10
    '{1,1,10'h30B,ONES,64'h0,2'b00,7},                     // R7
    '{0,0,10'h31B,64'h0,64'h1234_5678_8408_0080,2'b00,7},  // R7
    '{1,0,10'h30B,64'h0,64'h8400_0080,2'b00,6},            // R6
    '{0,1,10'h311,64'hAAAA_AAAA_AAAA_AAAA,64'h0,2'b00,2},
    '{1,1,10'h301,64'h5555_5555_5555_5555,64'h0,2'b00,7},  // R7
    '{0,0,10'h311,64'h0,64'hAAEA_8ABA_A2AE_A8AA,2'b00,7},  // R7
    '{1,0,10'h301,64'h0,64'h0040_0010_0004_0000,2'b00,6},  // R6
    '{1,1,10'h303,64'hDEAD_BEEF,64'h0,2'b00,8},            // R8
    '{0,0,10'h313,64'h0,64'hDEAD_BEEF,2'b00,8},            // R8
    '{0,1,10'h318,64'hFFFF_FFFF_0000_0006,64'h0,2'b00,2},
    '{1,0,10'h308,64'h0,64'h6,2'b00,8},                    // R8, R2 32-bit store
    '{0,1,10'h316,64'h44,64'h0,2'b00,2},
    '{0,1,10'h31E,64'h1111,64'h0,2'b00,2},
    '{0,1,10'h31B,64'h000C_0000,64'h0,2'b00,5},            // field = 11
    '{1,0,10'h307,64'h0,64'h0,2'b01,5},                    // R5
    '{1,1,10'h308,64'h99,64'h0,2'b01,5},                   // R5
    '{0,0,10'h318,64'h0,64'h6,2'b00,5},                    // R5 unchanged
    '{1,0,10'h306,64'h0,64'h44,2'b00,5},                   // R5 counter 4 open
    '{1,1,10'h30E,ONES,64'h0,2'b00,9},                     // R9
    '{0,0,10'h31E,64'h0,64'h1111,2'b00,9},                 // R9 unchanged
    '{0,0,10'h200,64'h0,64'h0,2'b00,9},                    // R9
    '{0,0,10'h31B,64'h0,64'h000C_0000,2'b00,2}             // R2
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic u, input logic w, input logic [9:0] a, input logic [63:0] d);
    req_valid = 1; req_user = u; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    check("R1 rsp_fault", 64'(rsp_fault), 0);
    check("R10 ready", 64'(req_ready), 1);
    xfer(0, 0, 10'h31B, 0);
    check("R1 ctl0 zero", rsp_rdata, 0);
    check("R10 rsp_valid", 64'(rsp_valid), 1);

    for (int i = 0; i < NV; i++) begin
      req_valid = 1; req_user = VEC[i].u; req_write = VEC[i].w;
      req_addr = VEC[i].a; req_wdata = VEC[i].d;
      @(negedge clk);
      check($sformatf("R%0d vec %0d data", VEC[i].r, i), rsp_rdata, VEC[i].er);
      check($sformatf("R%0d vec %0d fault", VEC[i].r, i), 64'(rsp_fault), 64'(VEC[i].ef));
      check($sformatf("R10 vec %0d valid", i), 64'(rsp_valid), 1);
    end
    req_valid = 0;
    @(negedge clk);
    check("R10 idle", 64'(rsp_valid), 0);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R1 valid after reset", 64'(rsp_valid), 0);
    xfer(0, 0, 10'h313, 0);
    check("R1 counter cleared", rsp_rdata, 0);
    xfer(0, 0, 10'h311, 0);
    check("R1 ctl2 cleared", rsp_rdata, 0);
    xfer(0, 0, 10'h31E, 0);
    check("R1 ctl1 cleared", rsp_rdata, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule